// File: doc/BRIEF.md
# Dual Programmable Baud Clock Generator

This block derives two independent 16x bit-rate clock enables, one for a transmit path and one for a receive path, from a single reference clock. Each section takes a 4-bit rate select code. The code passes into a small holding register, which a level-sensitive strobe controls. A fixed lookup turns the held code into a division ratio. The ratios assume a 5.0688 MHz reference: code 0 gives a 0.8 kHz tick rate (50 baud) and code 14 gives 153.6 kHz (9600 baud).

Each section has a down-counter. When the counter reaches zero it reloads from the lookup and raises its tick output for exactly one reference cycle. A newly selected rate therefore starts at the next reload, and the interval already running is never cut short. A serial transmitter or receiver in the same clock domain uses each tick as its oversampling enable.

The strobe can be pulsed to capture a code, or tied high so that the section follows its code inputs directly.

Top module: `baud_pair_gen`

## Requirements
- R1: While `rst` is high (sampled on a rising edge), both ticks are low, both counters clear and both held codes become 0, whatever the strobe and code inputs are. In the first cycle after release, both ticks pulse, and the next pulses come 6336 cycles later.
- R2: With held codes 0 to 7, the spacing between consecutive ticks is 6336, 4224, 2880, 2355, 2112, 1056, 528 and 264 reference cycles respectively.
- R3: With held codes 8 to 15, the spacing between consecutive ticks is 176, 158, 132, 88, 66, 44, 33 and 16 reference cycles respectively.
- R4: Each tick is high for exactly one reference cycle.
- R5: While a section's strobe is low, its held code does not change, so changing the code inputs leaves the tick spacing unchanged.
- R6: While a section's strobe is high, the held code follows the code inputs on every clock, so a strobe tied high tracks code changes without any pulse.
- R7: A change of held code takes effect only at the next counter reload. The interval in progress keeps its old length and the following interval has the new length.
- R8: The two sections are independent: the code and strobe of one never alter the tick spacing of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (nominally 5.0688 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| tx_addr | input | 4 | Transmit section rate select code |
| tx_stb | input | 1 | Transmit code strobe; high = held code follows `tx_addr` |
| rx_addr | input | 4 | Receive section rate select code |
| rx_stb | input | 1 | Receive code strobe; high = held code follows `rx_addr` |
| tx_tick | output | 1 | Transmit 16x enable, one cycle wide |
| rx_tick | output | 1 | Receive 16x enable, one cycle wide |

## Verification
A corrupted held code has no immediate effect at the ports. It appears only as a wrong tick spacing, starting after the next reload, so it can take up to one full old interval (6336 cycles at worst) before any difference is visible. A faulty counter decrement or reload shows up within one interval, as a wrongly spaced tick or a tick wider than one cycle. The bench therefore measures the interval after the one in which a change is made, and the internal checker compares counter and held-code state every cycle.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int unsigned SEL_W    = 4;
    localparam int unsigned NUM_SECT = 2;
    localparam int unsigned MAX_DIV  = 6336;
    localparam int unsigned CNT_W    = $clog2(MAX_DIV);

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
        logic tick;
    } div_state_t;

    // Division ratio for each rate select code, 5.0688 MHz reference.
    function automatic int unsigned rate_ratio(input sel_t code);
        int unsigned r;
        case (code)
            4'd0:    r = 6336;
            4'd1:    r = 4224;
            4'd2:    r = 2880;
            4'd3:    r = 2355;
            4'd4:    r = 2112;
            4'd5:    r = 1056;
            4'd6:    r = 528;
            4'd7:    r = 264;
            4'd8:    r = 176;
            4'd9:    r = 158;
            4'd10:   r = 132;
            4'd11:   r = 88;
            4'd12:   r = 66;
            4'd13:   r = 44;
            4'd14:   r = 33;
            default: r = 16;
        endcase
        return r;
    endfunction

    // Counter start value: a down count from ratio-1 to 0 spans ratio cycles.
    function automatic cnt_t reload_value(input sel_t code);
        return cnt_t'(rate_ratio(code) - 1);
    endfunction

endpackage

// File: rtl/rate_latch.sv
module rate_latch
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stb_i,
    input  sel_t code_i,
    output sel_t sel_o
);

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (rst) begin
            sel_d = '0;
        end else if (stb_i) begin
            sel_d = code_i;
        end
    end

    always_ff @(posedge clk) begin
        sel_q <= sel_d;
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/rate_divider.sv
module rate_divider
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sel_t sel_i,
    output logic tick_o,
    output cnt_t cnt_o
);

    div_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (rst) begin
            st_d = '0;
        end else if (st_q.cnt == '0) begin
            st_d.cnt  = reload_value(sel_i);
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/baud_pair_gen.sv
module baud_pair_gen
    import baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] tx_addr,
    input  logic       tx_stb,
    input  logic [3:0] rx_addr,
    input  logic       rx_stb,
    output logic       tx_tick,
    output logic       rx_tick
);

    localparam int unsigned TX = 0;
    localparam int unsigned RX = 1;

    logic [NUM_SECT-1:0]            stb_w;
    logic [NUM_SECT-1:0][SEL_W-1:0] code_w;
    logic [NUM_SECT-1:0][SEL_W-1:0] sel_w;
    logic [NUM_SECT-1:0][CNT_W-1:0] cnt_w;
    logic [NUM_SECT-1:0]            tick_w;

    assign stb_w[TX]  = tx_stb;
    assign stb_w[RX]  = rx_stb;
    assign code_w[TX] = tx_addr;
    assign code_w[RX] = rx_addr;

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        rate_latch u_latch (
            .clk    (clk),
            .rst    (rst),
            .stb_i  (stb_w[g]),
            .code_i (code_w[g]),
            .sel_o  (sel_w[g])
        );

        rate_divider u_div (
            .clk    (clk),
            .rst    (rst),
            .sel_i  (sel_w[g]),
            .tick_o (tick_w[g]),
            .cnt_o  (cnt_w[g])
        );
    end

    assign tx_tick = tick_w[TX];
    assign rx_tick = tick_w[RX];

endmodule

// File: rtl/baud_pair_chk.sv
module baud_pair_chk
    import baud_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_SECT-1:0]             stb_w,
    input logic [NUM_SECT-1:0][SEL_W-1:0]  code_w,
    input logic [NUM_SECT-1:0][SEL_W-1:0]  sel_w,
    input logic [NUM_SECT-1:0][CNT_W-1:0]  cnt_w,
    input logic [NUM_SECT-1:0]             tick_w
);

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_chk
        // R1
        reset_state_chk: assert property (@(posedge clk)
            rst |=> (sel_w[g] == '0 && cnt_w[g] == '0 && !tick_w[g]));

        // R4
        pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
            tick_w[g] |=> !tick_w[g]);

        // R5
        hold_code_chk: assert property (@(posedge clk) disable iff (rst)
            !stb_w[g] |=> $stable(sel_w[g]));

        // R6
        follow_code_chk: assert property (@(posedge clk) disable iff (rst)
            stb_w[g] |=> sel_w[g] == $past(code_w[g]));

        // R7
        steady_count_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt_w[g] != '0) |=> (cnt_w[g] == $past(cnt_w[g]) - 1'b1 && !tick_w[g]));
    end

endmodule

bind baud_pair_gen baud_pair_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .stb_w  (stb_w),
    .code_w (code_w),
    .sel_w  (sel_w),
    .cnt_w  (cnt_w),
    .tick_w (tick_w)
);

// File: tb/test_baud_pair_gen.sv
`timescale 1ns/1ps
module test_baud_pair_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] tx_addr = 4'd9;
    logic       tx_stb  = 1'b1;
    logic [3:0] rx_addr = 4'd9;
    logic       rx_stb  = 1'b1;
    logic       tx_tick, rx_tick;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit done = 1'b0;

    // code, expected tick spacing
    localparam int unsigned VEC [16][2] = '{
        '{0, 6336}, '{1, 4224}, '{2, 2880}, '{3, 2355},
        '{4, 2112}, '{5, 1056}, '{6, 528},  '{7, 264},
        '{8, 176},  '{9, 158},  '{10, 132}, '{11, 88},
        '{12, 66},  '{13, 44},  '{14, 33},  '{15, 16}
    };

    baud_pair_gen i_baud_pair_gen (
        .clk     (clk),
        .rst     (rst),
        .tx_addr (tx_addr),
        .tx_stb  (tx_stb),
        .rx_addr (rx_addr),
        .rx_stb  (rx_stb),
        .tx_tick (tx_tick),
        .rx_tick (rx_tick)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(input int ch, output int t);
        forever begin
            @(negedge clk);
            if ((ch == 0) ? tx_tick : rx_tick) break;
        end
        t = cyc;
    endtask

    task automatic load(input int ch, input logic [3:0] code);
        @(negedge clk);
        if (ch == 0) begin tx_addr = code; tx_stb = 1'b1; end
        else         begin rx_addr = code; rx_stb = 1'b1; end
        @(negedge clk);
        if (ch == 0) tx_stb = 1'b0;
        else         rx_stb = 1'b0;
    endtask

    // Spacing of the third tick after the call.
    task automatic settled_gap(input int ch, output int gap);
        int t0, t1, t2;
        wait_tick(ch, t0);
        wait_tick(ch, t1);
        wait_tick(ch, t2);
        gap = t2 - t1;
    endtask

    initial begin
        int ta, tb, gap;

        // R1: reset overrides strobe and codes
        repeat (5) begin
            @(negedge clk);
            check(!tx_tick && !rx_tick, "R1 ticks in reset", int'(tx_tick) + int'(rx_tick), 0);
        end
        rst = 1'b0; tx_stb = 1'b0; rx_stb = 1'b0;
        @(negedge clk);
        check(tx_tick && rx_tick, "R1 first pulse", int'(tx_tick) + int'(rx_tick), 2);
        ta = cyc;
        wait_tick(0, tb);
        check(tb - ta == 6336, "R1 code 0 after reset", tb - ta, 6336);
        check(rx_tick == 1'b1, "R1 rx aligned", int'(rx_tick), 1);

        // receive section parked at code 8 during the transmit sweep
        load(1, 4'd8);

        // R2 / R3: full transmit table sweep
        for (int i = 0; i < 16; i++) begin
            load(0, 4'(VEC[i][0]));
            settled_gap(0, gap);
            check(gap == int'(VEC[i][1]), (i < 8) ? "R2 tx spacing" : "R3 tx spacing",
                  gap, int'(VEC[i][1]));
            @(negedge clk);
            check(!tx_tick, "R4 tx pulse width", int'(tx_tick), 0);
        end

        // R8: receive spacing untouched by transmit sweep
        settled_gap(1, gap);
        check(gap == 176, "R8 rx independent", gap, 176);

        // R3: receive section table, transmit stays at code 15
        for (int i = 8; i < 16; i++) begin
            load(1, 4'(VEC[i][0]));
            settled_gap(1, gap);
            check(gap == int'(VEC[i][1]), "R3 rx spacing", gap, int'(VEC[i][1]));
            @(negedge clk);
            check(!rx_tick, "R4 rx pulse width", int'(rx_tick), 0);
        end
        settled_gap(0, gap);
        check(gap == 16, "R8 tx independent", gap, 16);

        // R5: code change with strobe low is ignored
        @(negedge clk);
        tx_addr = 4'd0;
        settled_gap(0, gap);
        check(gap == 16, "R5 hold with strobe low", gap, 16);

        // R6: strobe tied high follows codes
        @(negedge clk);
        tx_stb = 1'b1; tx_addr = 4'd14;
        settled_gap(0, gap);
        check(gap == 33, "R6 follow code 14", gap, 33);
        @(negedge clk);
        tx_addr = 4'd12;
        settled_gap(0, gap);
        check(gap == 66, "R6 follow code 12", gap, 66);
        @(negedge clk);
        tx_stb = 1'b0;

        // R7: mid-interval change completes old interval first
        load(0, 4'd5);
        settled_gap(0, gap);
        ta = cyc;
        repeat (300) @(negedge clk);
        load(0, 4'd15);
        wait_tick(0, tb);
        check(tb - ta == 1056, "R7 old interval kept", tb - ta, 1056);
        wait_tick(0, ta);
        check(ta - tb == 16, "R7 new interval", ta - tb, 16);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected=0", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule